// File: doc/BRIEF.md
# Long-Word Write Width Upsizer

This block sits in front of the write side of a 36-bit FIFO and accepts data from a port that can be 36, 18 or 9 bits wide. In the narrow modes it keeps the early parts of each long word in auxiliary lane registers. On the clock edge that accepts the final part, it presents the whole 36-bit word on the FIFO side together with a push strobe. The FIFO therefore only ever receives whole long words. A port write takes effect when the write enable and the ready flag are both high on a rising edge.

The width is set by a static size input. The lane order is set by an endian input. Both are sampled while the block is held in reset and frozen once it starts running, which happens by the time the ready flag first rises. In big-endian order the first part received becomes the most significant part of the long word. In little-endian order the first part becomes the least significant. Ready is withheld only when the FIFO is full and the next write would complete a long word. Writes made while ready is low are dropped.

Top module: `wr_upsizer`

## Requirements
- R1: While reset is asserted, in_ready and push are low. After reset is released, in_ready rises within four clock cycles when fifo_full is low.
- R2: With size_sel = 2'b00 (36-bit), every accepted write drives push high in the same cycle, and push_data equals wr_data.
- R3: With size_sel = 2'b01 (18-bit), push stays low on the first accepted word and rises combinationally on the second accepted word. The assembled 36-bit word is on push_data in that cycle.
- R4: With size_sel = 2'b10 (9-bit), push rises only on the fourth accepted byte, and the full long word is presented in that same cycle.
- R5: Input bits above the selected width are ignored. In 9-bit mode only wr_data[8:0] is used, and in 18-bit mode only wr_data[17:0] is used.
- R6: With be_sel low at reset, the first part received lands in the least significant lanes. A byte k goes to bits [9k+8:9k], and a word k goes to bits [18k+17:18k].
- R7: With be_sel high at reset, the first part received lands in the most significant lanes. A byte k goes to bits [9(3-k)+8:9(3-k)], and a word k goes to bits [18(1-k)+17:18(1-k)].
- R8: Size and endian are taken from their inputs while reset is in effect. Changing be_sel after in_ready has risen has no effect on lane placement.
- R9: in_ready is low when fifo_full is high and the next accepted write would complete a long word. It stays high while fifo_full is high and the next write would not complete one.
- R10: A write attempted while in_ready is low is dropped. It leaves no trace in the assembled word, and the part position does not advance.
- R11: Reset clears a partly assembled word. After reset, assembly starts again at the first part.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| size_sel | input | 2 | Port width: 00 = 36, 01 = 18, 10 = 9 bits (11 acts as 36) |
| be_sel | input | 1 | High selects big-endian lane order; sampled during reset |
| wr_en | input | 1 | Port-side write request |
| wr_data | input | 36 | Port-side write data |
| in_ready | output | 1 | The block can accept a write this cycle |
| fifo_full | input | 1 | The downstream FIFO is full |
| push | output | 1 | Write strobe for one whole long word into the FIFO |
| push_data | output | 36 | Assembled long word |

## Verification
The bench builds the block with its default parameters: 9-bit lanes, four lanes to a long word, and a two-stage reset synchronizer. With this configuration all three widths and both lane orders can be swept completely. Every size and endian pair is crossed with a set of arithmetically generated long words, and every input bit above the selected width is driven high, so that misplaced lanes and leaking unused bits both show up. Directed cases then cover a full FIFO at each part position, a write dropped in the middle of a word, a change of be_sel while running, and a reset in the middle of a word.

// File: rtl/upsz_pkg.sv
package upsz_pkg;

  typedef enum logic [1:0] {
    SZ_LONG = 2'b00,
    SZ_WORD = 2'b01,
    SZ_BYTE = 2'b10
  } size_e;

endpackage

// File: rtl/upsz_rst_sync.sv
module upsz_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/upsz_cfg.sv
module upsz_cfg
  import upsz_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rst_sync_n,
  input  logic [1:0] size_sel,
  input  logic       be_sel,
  output logic       run,
  output size_e      mode,
  output logic       big
);

  logic  run_q;
  logic  run_d;
  size_e mode_q;
  size_e mode_d;
  size_e mode_dec;
  logic  big_q;
  logic  big_d;

  always_comb begin
    case (size_sel)
      2'b01:   mode_dec = SZ_WORD;
      2'b10:   mode_dec = SZ_BYTE;
      default: mode_dec = SZ_LONG;
    endcase
  end

  // Selections load every cycle until the block starts running, then freeze.
  always_comb begin
    run_d  = rst_sync_n;
    mode_d = run_q ? mode_q : mode_dec;
    big_d  = run_q ? big_q  : be_sel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
    end else begin
      run_q <= run_d;
    end
  end

  always_ff @(posedge clk) begin
    mode_q <= mode_d;
    big_q  <= big_d;
  end

  assign run  = run_q;
  assign mode = mode_q;
  assign big  = big_q;

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && $past(run_q)) |-> ($stable(big_q) && $stable(mode_q))); // R8

endmodule

// File: rtl/upsz_ctrl.sv
module upsz_ctrl
  import upsz_pkg::*;
#(
  parameter int LANES = 4,
  localparam int CW = $clog2(LANES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  size_e         mode,
  input  logic          wr_en,
  input  logic          fifo_full,
  output logic [CW-1:0] cnt,
  output logic          accept,
  output logic          in_ready,
  output logic          push
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          last;

  always_comb begin
    case (mode)
      SZ_WORD: last = (cnt_q == CW'(1));
      SZ_BYTE: last = (cnt_q == CW'(LANES - 1));
      default: last = 1'b1;
    endcase
  end

  always_comb begin
    in_ready = run && !(fifo_full && last);
    accept   = wr_en && in_ready;
    push     = accept && last;
  end

  always_comb begin
    cnt_d = cnt_q;
    if (!run) begin
      cnt_d = '0;
    end else if (accept) begin
      cnt_d = last ? '0 : cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt = cnt_q;

  AST_WRAP_AFTER_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> (cnt_q == '0)); // R4
  AST_HOLD_ON_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (run && wr_en && !in_ready) |=> $stable(cnt_q)); // R10
  AST_WORD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (run && mode == SZ_WORD) |-> (cnt_q <= CW'(1))); // R3

endmodule

// File: rtl/upsz_pack.sv
module upsz_pack
  import upsz_pkg::*;
#(
  parameter int LANE_W = 9,
  parameter int LANES  = 4,
  localparam int CW = $clog2(LANES),
  localparam int DW = LANE_W * LANES,
  localparam int H  = LANES / 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  size_e         mode,
  input  logic          big,
  input  logic          accept,
  input  logic [CW-1:0] cnt,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] push_data
);

  logic [LANES-2:0][LANE_W-1:0] aux_q;
  logic [LANES-2:0][LANE_W-1:0] aux_d;
  logic [LANES-2:0][LANE_W-1:0] aux_nxt;
  logic [LANES-1:0][LANE_W-1:0] arr;

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    localparam int QW = j / H;
    localparam int RW = j % H;
    localparam int BWORD = (1 - QW) * H + RW;
    localparam int BBYTE = LANES - 1 - j;

    logic              live;
    logic [LANE_W-1:0] src;
    logic [LANE_W-1:0] outl;

    // Which input lane feeds arrival lane j, and whether it arrives now.
    always_comb begin
      case (mode)
        SZ_WORD: begin
          live = (cnt == CW'(QW));
          src  = wr_data[RW*LANE_W +: LANE_W];
        end
        SZ_BYTE: begin
          live = (cnt == CW'(j));
          src  = wr_data[LANE_W-1:0];
        end
        default: begin
          live = 1'b1;
          src  = wr_data[j*LANE_W +: LANE_W];
        end
      endcase
    end

    if (j < LANES - 1) begin : g_aux
      assign aux_d[j] = (accept && live) ? src : aux_q[j];
      assign arr[j]   = live ? src : aux_q[j];
    end else begin : g_top
      assign arr[j] = src;
    end

    // Lane reordering for the selected endian order.
    always_comb begin
      if (!big) begin
        outl = arr[j];
      end else begin
        case (mode)
          SZ_WORD: outl = arr[BWORD];
          SZ_BYTE: outl = arr[BBYTE];
          default: outl = arr[j];
        endcase
      end
    end

    assign push_data[j*LANE_W +: LANE_W] = outl;
  end

  always_comb begin
    aux_nxt = run ? aux_d : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      aux_q <= '0;
    end else begin
      aux_q <= aux_nxt;
    end
  end

  AST_AUX_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && !accept) |=> $stable(aux_q)); // R10

endmodule

// File: rtl/wr_upsizer.sv
module wr_upsizer
  import upsz_pkg::*;
#(
  parameter int LANE_W      = 9,
  parameter int LANES       = 4,
  parameter int SYNC_STAGES = 2,
  localparam int DW = LANE_W * LANES,
  localparam int CW = $clog2(LANES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    size_sel,
  input  logic          be_sel,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic          in_ready,
  input  logic          fifo_full,
  output logic          push,
  output logic [DW-1:0] push_data
);

  logic          rst_sync_n;
  logic          run;
  size_e         mode;
  logic          big;
  logic          accept;
  logic [CW-1:0] cnt;

  upsz_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  upsz_cfg u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n),
    .size_sel   (size_sel),
    .be_sel     (be_sel),
    .run        (run),
    .mode       (mode),
    .big        (big)
  );

  upsz_ctrl #(.LANES(LANES)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .mode      (mode),
    .wr_en     (wr_en),
    .fifo_full (fifo_full),
    .cnt       (cnt),
    .accept    (accept),
    .in_ready  (in_ready),
    .push      (push)
  );

  upsz_pack #(.LANE_W(LANE_W), .LANES(LANES)) u_pack (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .mode      (mode),
    .big       (big),
    .accept    (accept),
    .cnt       (cnt),
    .wr_data   (wr_data),
    .push_data (push_data)
  );

  AST_NO_PUSH_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !fifo_full); // R9
  AST_LONG_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    (run && mode == SZ_LONG && wr_en && in_ready) |-> (push && push_data == wr_data)); // R2
  AST_PUSH_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (wr_en && in_ready)); // R10

endmodule

// File: tb/wr_upsizer_bench.sv
module wr_upsizer_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  size_sel = 2'b00;
  logic        be_sel = 1'b0;
  logic        wr_en = 1'b0;
  logic [35:0] wr_data = '0;
  logic        fifo_full = 1'b0;
  logic        in_ready;
  logic        push;
  logic [35:0] push_data;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  wr_upsizer u_wr_upsizer (
    .clk       (clk),
    .rst_n     (rst_n),
    .size_sel  (size_sel),
    .be_sel    (be_sel),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .in_ready  (in_ready),
    .fifo_full (fifo_full),
    .push      (push),
    .push_data (push_data)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int piece_w(input int sz);
    return (sz == 0) ? 36 : ((sz == 1) ? 18 : 9);
  endfunction

  // Part k of long word w as driven on the port; unused upper bits set high.
  function automatic logic [35:0] piece(input logic [35:0] w, input int sz, input bit bg, input int k);
    int pw = piece_w(sz);
    int np = 36 / pw;
    int idx = bg ? (np - 1 - k) : k;
    logic [35:0] m = (pw == 36) ? '1 : ((36'd1 << pw) - 36'd1);
    return ((w >> (idx * pw)) & m) | ~m;
  endfunction

  task automatic do_reset(input int sz, input bit bg);
    @(negedge clk);
    rst_n = 1'b0;
    wr_en = 1'b0;
    fifo_full = 1'b0;
    size_sel = sz[1:0];
    be_sel = bg;
    #1;
    check(!in_ready && !push, "R1 reset outputs", {in_ready, push}, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    check(in_ready == 1'b1, "R1 ready after release", in_ready, 1);
  endtask

  // Drive one part at the negedge and sample the combinational result before the posedge.
  task automatic send_part(input logic [35:0] w, input int sz, input bit bg, input int k, input string tag);
    int np = 36 / piece_w(sz);
    bit lst = (k == np - 1);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = piece(w, sz, bg, k);
    #1;
    check(push == lst, {tag, " push"}, push, lst);
    if (lst) check(push_data == w, {tag, " data"}, push_data, w);
    @(posedge clk);
    #1;
    wr_en = 1'b0;
  endtask

  task automatic send_word(input logic [35:0] w, input int sz, input bit bg, input string tag);
    for (int k = 0; k < 36 / piece_w(sz); k++) send_part(w, sz, bg, k, tag);
  endtask

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    string tg;
    logic [35:0] w;
    logic [63:0] prod;

    // Sweep: every width and endian order over generated long words (R2..R7, R5 via high unused bits).
    for (int sz = 0; sz < 3; sz++) begin
      for (int bg = 0; bg < 2; bg++) begin
        do_reset(sz, bit'(bg));
        for (int p = 0; p < 6; p++) begin
          prod = 64'h9E3779B97F4A7C15 * 64'(p + 1);
          w = prod[35:0] ^ prod[63:28];
          if (p == 5) w = 36'h0_0000_0000;
          tg = (sz == 0) ? "R2" : ((sz == 1) ? "R3" : "R4");
          tg = {tg, bg ? " R7" : " R6", " R5"};
          send_word(w, sz, bit'(bg), tg);
        end
      end
    end

    // R8: be_sel changed after start has no effect.
    do_reset(1, 1'b0);
    be_sel = 1'b1;
    send_word(36'hA_BCDE_1234, 1, 1'b0, "R8 frozen endian");

    // R9 and R10: full FIFO at each part position, dropped write mid-word.
    do_reset(1, 1'b0);
    w = 36'h5_A5A5_3C3C;
    @(negedge clk);
    fifo_full = 1'b1;
    #1;
    check(in_ready == 1'b1, "R9 ready when full but not completing", in_ready, 1);
    send_part(w, 1, 1'b0, 0, "R9 first word under full");
    @(negedge clk);
    #1;
    check(in_ready == 1'b0, "R9 not ready on completing part", in_ready, 0);
    wr_en = 1'b1;
    wr_data = 36'hF_FFFF_FFFF;
    #1;
    check(push == 1'b0, "R10 dropped write no push", push, 0);
    @(posedge clk);
    #1;
    wr_en = 1'b0;
    @(negedge clk);
    fifo_full = 1'b0;
    send_part(w, 1, 1'b0, 1, "R10 word after drop");

    do_reset(0, 1'b0);
    @(negedge clk);
    fifo_full = 1'b1;
    #1;
    check(in_ready == 1'b0, "R9 long mode full", in_ready, 0);
    @(negedge clk);
    fifo_full = 1'b0;

    // R11: reset in the middle of a byte-mode word.
    do_reset(2, 1'b1);
    send_part(36'h1_1111_1111, 2, 1'b1, 0, "R11 partial");
    send_part(36'h1_1111_1111, 2, 1'b1, 1, "R11 partial");
    do_reset(2, 1'b1);
    send_word(36'h8_7654_3210, 2, 1'b1, "R11 fresh word");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule